// File: doc/BRIEF.md
# Four-Bit Block ADPCM Frame Decoder

This block expands compressed audio into signed 16-bit PCM. Input arrives one byte at a time over a valid/ready port, grouped into frames of eight bytes. The first byte of each frame is a header and the other seven carry fourteen 4-bit codes. The header's upper field picks one of eight coefficient pairs. Its lower field gives a left shift applied to each code. Every sample is a second-order prediction from the two previous outputs plus the shifted code, rounded and saturated to 16 bits. The history runs on from one frame to the next.

The coefficient pairs live in a small register file that is written through a separate write port, normally before decoding starts. A preset port can load or clear the prediction history, for example when a new stream begins. Decoded samples leave on a valid/ready stream.

The controller has four states. HEADER accepts a header byte and moves to FETCH. FETCH accepts a data byte and moves to EMIT_HI. EMIT_HI offers the sample for the upper code and moves to EMIT_LO when it is taken. EMIT_LO offers the sample for the lower code. When that sample is taken, EMIT_LO returns to FETCH, or to HEADER once the seventh data byte of the frame is used up.

Top module: `adpcm_dec`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. Both history registers and every coefficient are 0.
- R2: A frame is one header byte followed by 7 data bytes and yields exactly 14 samples. in_ready and out_valid are never high together. After the 14th sample is taken, the block waits for a new header.
- R3: Within a data byte, the code in bits 7:4 is decoded before the code in bits 3:0. Each code is a two's-complement value from -8 to 7.
- R4: Header bits 3:0 give the shift S, and header bits 7:4 give the pair index K. Coefficient write address 2K holds c1, which weights the newest history sample h1. Address 2K+1 holds c2, which weights the older history sample h2. Coefficients are signed 16-bit values.
- R5: Each sample is floor(((code·2^S)·2048 + c1·h1 + c2·h2 + 1024) / 2048).
- R6: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R7: A pair index of 8 or more makes all 14 samples of that frame 0. The history then fills with those zeros.
- R8: Each time a sample is taken, h2 takes the old value of h1 and h1 takes the sample. The history carries across frame boundaries.
- R9: A pulse on hist_load sets h1 and h2 from the preset inputs. The preset takes priority over a sample update in the same cycle.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_sample does not change.
- R11: A coefficient write takes effect for every sample produced after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient address (2K for c1, 2K+1 for c2) |
| coef_wdata | input | 16 | Signed coefficient value |
| hist_load | input | 1 | Preset the prediction history |
| hist_h1_in | input | 16 | Preset value for the newest history sample |
| hist_h2_in | input | 16 | Preset value for the older history sample |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_byte | input | 8 | Frame byte (header or data) |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | 16 | Signed PCM sample |

## Verification
The first frames use zero coefficients with shift 0. Each output then equals its code, which exposes the nibble order and the sign handling without any prediction involved. Later frames use a pure integrator pair, a pair with a negative second tap, and full-scale taps with shift 15. These separate the c1 and c2 weights, the rounding and floor behaviour, and saturation at both limits. They also check that history crosses frame boundaries. Frames with an out-of-range index are mixed between valid ones, so the zero output and the emptied history show up in the frame that follows. Stalled handshakes, a history preset, a reset in the middle of a frame and a coefficient rewrite between identical frames cover holding, presetting, clearing and update timing.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int COEF_W     = 16;
    localparam int FRAC_BITS  = 11;
    localparam int CODE_W     = 4;
    localparam int NUM_PAIRS  = 8;
    localparam int DATA_BYTES = 7;

    typedef enum logic [1:0] {
        ST_HEADER  = 2'd0,
        ST_FETCH   = 2'd1,
        ST_EMIT_HI = 2'd2,
        ST_EMIT_LO = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic [3:0] index;
        logic [3:0] scale;
    } frame_hdr_t;

endpackage

// File: rtl/adpcm_coef_bank.sv
module adpcm_coef_bank #(
    parameter int PAIRS  = 8,
    parameter int COEF_W = 16,
    parameter int ADDR_W = $clog2(2 * PAIRS),
    parameter int SEL_W  = $clog2(PAIRS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [SEL_W-1:0]         sel,
    output logic signed [COEF_W-1:0] c1,
    output logic signed [COEF_W-1:0] c2
);
    localparam int ENTRIES = 2 * PAIRS;

    logic signed [COEF_W-1:0] regs [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (waddr == ADDR_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        c1 = regs[{sel, 1'b0}];
        c2 = regs[{sel, 1'b1}];
    end

endmodule

// File: rtl/adpcm_predictor.sv
module adpcm_predictor #(
    parameter int SAMPLE_W  = 16,
    parameter int COEF_W    = 16,
    parameter int FRAC_BITS = 11,
    parameter int CODE_W    = 4
) (
    input  logic [CODE_W-1:0]          code,
    input  logic [3:0]                 scale,
    input  logic signed [COEF_W-1:0]   c1,
    input  logic signed [COEF_W-1:0]   c2,
    input  logic signed [SAMPLE_W-1:0] h1,
    input  logic signed [SAMPLE_W-1:0] h2,
    input  logic                       force_zero,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int ACC_W = COEF_W + SAMPLE_W + 8;
    localparam logic signed [ACC_W-1:0] ROUND = ACC_W'(2 ** (FRAC_BITS - 1));
    localparam logic signed [ACC_W-1:0] MAXV  = ACC_W'(2 ** (SAMPLE_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MINV  = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] code_term;
    logic signed [ACC_W-1:0] prod1;
    logic signed [ACC_W-1:0] prod2;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        code_term = ACC_W'($signed(code)) <<< (32'(scale) + FRAC_BITS);
        prod1     = ACC_W'(c1) * ACC_W'(h1);
        prod2     = ACC_W'(c2) * ACC_W'(h2);
        acc       = code_term + prod1 + prod2 + ROUND;
        scaled    = acc >>> FRAC_BITS;
        if (force_zero) begin
            sample = '0;
        end else if (scaled > MAXV) begin
            sample = SAMPLE_W'(MAXV);
        end else if (scaled < MINV) begin
            sample = SAMPLE_W'(MINV);
        end else begin
            sample = SAMPLE_W'(scaled);
        end
    end

endmodule

// File: rtl/adpcm_dec.sv
module adpcm_dec
    import adpcm_pkg::*;
#(
    parameter int SAMPLE_W   = adpcm_pkg::SAMPLE_W,
    parameter int COEF_W     = adpcm_pkg::COEF_W,
    parameter int PAIRS      = adpcm_pkg::NUM_PAIRS,
    parameter int DATA_BYTES = adpcm_pkg::DATA_BYTES,
    parameter int CA_W       = $clog2(2 * PAIRS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       coef_we,
    input  logic [CA_W-1:0]            coef_addr,
    input  logic signed [COEF_W-1:0]   coef_wdata,
    input  logic                       hist_load,
    input  logic signed [SAMPLE_W-1:0] hist_h1_in,
    input  logic signed [SAMPLE_W-1:0] hist_h2_in,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [7:0]                 in_byte,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    localparam int SEL_W = $clog2(PAIRS);
    localparam int CNT_W = $clog2(DATA_BYTES);

    dec_state_e                 state_q, state_d;
    frame_hdr_t                 hdr_q;
    logic [7:0]                 byte_q;
    logic [CNT_W-1:0]           cnt_q;
    logic signed [SAMPLE_W-1:0] h1_q, h2_q;

    logic                       in_fire, out_fire;
    logic                       last_byte;
    logic                       bad_index;
    logic [CODE_W-1:0]          code;
    logic signed [COEF_W-1:0]   c1, c2;
    logic signed [SAMPLE_W-1:0] pred_sample;

    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign last_byte = (cnt_q == CNT_W'(DATA_BYTES - 1));
    assign bad_index = (int'(hdr_q.index) >= PAIRS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEADER:  if (in_valid)  state_d = ST_FETCH;
            ST_FETCH:   if (in_valid)  state_d = ST_EMIT_HI;
            ST_EMIT_HI: if (out_ready) state_d = ST_EMIT_LO;
            ST_EMIT_LO: if (out_ready) state_d = last_byte ? ST_HEADER : ST_FETCH;
            default:                   state_d = ST_HEADER;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        code      = byte_q[7:4];
        unique case (state_q)
            ST_HEADER:  in_ready = 1'b1;
            ST_FETCH:   in_ready = 1'b1;
            ST_EMIT_HI: begin
                out_valid = 1'b1;
                code      = byte_q[7:4];
            end
            ST_EMIT_LO: begin
                out_valid = 1'b1;
                code      = byte_q[3:0];
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            byte_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (in_fire && state_q == ST_HEADER) begin
                hdr_q <= frame_hdr_t'(in_byte);
                cnt_q <= '0;
            end
            if (in_fire && state_q == ST_FETCH) begin
                byte_q <= in_byte;
            end
            if (out_fire && state_q == ST_EMIT_LO && !last_byte) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // prediction history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1_q <= '0;
            h2_q <= '0;
        end else if (hist_load) begin
            h1_q <= hist_h1_in;
            h2_q <= hist_h2_in;
        end else if (out_fire) begin
            h2_q <= h1_q;
            h1_q <= pred_sample;
        end
    end

    adpcm_coef_bank #(
        .PAIRS  (PAIRS),
        .COEF_W (COEF_W),
        .ADDR_W (CA_W),
        .SEL_W  (SEL_W)
    ) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_wdata),
        .sel   (hdr_q.index[SEL_W-1:0]),
        .c1    (c1),
        .c2    (c2)
    );

    adpcm_predictor #(
        .SAMPLE_W  (SAMPLE_W),
        .COEF_W    (COEF_W),
        .FRAC_BITS (FRAC_BITS),
        .CODE_W    (CODE_W)
    ) u_pred (
        .code       (code),
        .scale      (hdr_q.scale),
        .c1         (c1),
        .c2         (c2),
        .h1         (h1_q),
        .h2         (h2_q),
        .force_zero (bad_index),
        .sample     (pred_sample)
    );

    assign out_sample = pred_sample;

endmodule

// File: rtl/adpcm_dec_chk.sv
module adpcm_dec_chk #(
    parameter int SAMPLE_W = 16,
    parameter int PAIRS    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       coef_we,
    input logic                       hist_load,
    input logic signed [SAMPLE_W-1:0] hist_h1_in,
    input logic signed [SAMPLE_W-1:0] hist_h2_in,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic signed [SAMPLE_W-1:0] out_sample,
    input logic [3:0]                 hdr_index,
    input logic signed [SAMPLE_W-1:0] h1_q,
    input logic signed [SAMPLE_W-1:0] h2_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    // R2
    hs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !hist_load && !coef_we)
        |=> (out_valid && $stable(out_sample)));

    // R7
    bad_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(hdr_index) >= PAIRS) |-> (out_sample == '0));

    // R8
    history_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !hist_load)
        |=> (h1_q == $past(out_sample) && h2_q == $past(h1_q)));

    // R9
    history_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_load |=> (h1_q == $past(hist_h1_in) && h2_q == $past(hist_h2_in)));

endmodule

bind adpcm_dec adpcm_dec_chk #(
    .SAMPLE_W (SAMPLE_W),
    .PAIRS    (PAIRS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_we    (coef_we),
    .hist_load  (hist_load),
    .hist_h1_in (hist_h1_in),
    .hist_h2_in (hist_h2_in),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .hdr_index  (hdr_q.index),
    .h1_q       (h1_q),
    .h2_q       (h2_q)
);

// File: tb/adpcm_dec_tb.sv
module adpcm_dec_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               coef_we = 1'b0;
    logic [3:0]         coef_addr = '0;
    logic signed [15:0] coef_wdata = '0;
    logic               hist_load = 1'b0;
    logic signed [15:0] hist_h1_in = '0;
    logic signed [15:0] hist_h2_in = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [7:0]         in_byte = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic signed [15:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;
    int cm [16];
    int h1m = 0;
    int h2m = 0;

    always #2.5 clk = ~clk;

    adpcm_dec u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_wdata (coef_wdata),
        .hist_load  (hist_load),
        .hist_h1_in (hist_h1_in),
        .hist_h2_in (hist_h2_in),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sample (out_sample)
    );

    // row: [96] stall, [95:80] c1, [79:64] c2, [63:56] header, [55:0] data
    localparam int NROWS = 8;
    localparam logic [96:0] ROWS [NROWS] = '{
        {1'b0, 16'h0000, 16'h0000, 64'h00_7F_80_12_34_56_9A_EF},
        {1'b0, 16'h0800, 16'h0000, 64'h13_11_11_F1_1F_70_00_88},
        {1'b1, 16'h1000, 16'hF800, 64'h2B_77_77_21_00_99_CC_08},
        {1'b1, 16'h7FFF, 16'h8000, 64'h3F_78_87_70_07_80_08_FF},
        {1'b0, 16'h0000, 16'h0000, 64'h95_7F_7F_7F_7F_7F_7F_7F},
        {1'b1, 16'h05DC, 16'hFD44, 64'h71_35_AC_7E_01_F3_44_B2},
        {1'b0, 16'h0000, 16'h0000, 64'hF0_12_34_56_78_9A_BC_DE},
        {1'b0, 16'hFC00, 16'h0200, 64'h45_1F_E2_73_8C_55_AA_0F}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int code, input int sc, input int c1,
                                 input int c2, input int h1, input int h2);
        longint v;
        int s;
        s = (code >= 8) ? code - 16 : code;
        v = (longint'(s) * (longint'(1) << sc)) * 2048
            + longint'(c1) * h1 + longint'(c2) * h2 + 1024;
        v = v >>> 11;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    task automatic write_coef(input int addr, input logic [15:0] val);
        coef_we    = 1'b1;
        coef_addr  = 4'(addr);
        coef_wdata = val;
        @(posedge clk);
        #1;
        coef_we = 1'b0;
        cm[addr] = int'($signed(val));
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic recv(input int exp, input bit stall, input string req);
        logic signed [15:0] held;
        while (!out_valid) @(negedge clk);
        chk(in_ready == 1'b0, "R2 in_ready low during sample", int'(in_ready), 0);
        if (stall) begin
            held = out_sample;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(out_valid && out_sample == held, "R10 hold while stalled",
                    int'(out_sample), int'(held));
            end
        end
        chk(int'(out_sample) == exp, req, int'(out_sample), exp);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [63:0] fr, input bit stall, input string req);
        int idx, sc, e;
        logic [7:0] db;
        int code;
        idx = int'(fr[63:60]);
        sc  = int'(fr[59:56]);
        send_byte(fr[63:56]);
        for (int b = 0; b < 7; b++) begin
            db = fr[55 - 8*b -: 8];
            send_byte(db);
            for (int h = 0; h < 2; h++) begin
                code = (h == 0) ? int'(db[7:4]) : int'(db[3:0]);
                if (idx >= 8) e = 0;
                else e = model(code, sc, cm[2*idx], cm[2*idx+1], h1m, h2m);
                recv(e, stall, req);
                h2m = h1m;
                h1m = e;
            end
        end
        chk(in_ready && !out_valid, "R2 frame ends after 14 samples",
            int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) cm[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R5 R6 R7 R8 across carried history
        for (int r = 0; r < NROWS; r++) begin
            int idx;
            idx = int'(ROWS[r][63:60]);
            if (idx < 8) begin
                write_coef(2*idx,   ROWS[r][95:80]);
                write_coef(2*idx+1, ROWS[r][79:64]);
            end
            run_frame(ROWS[r][63:0], ROWS[r][96],
                      (idx >= 8) ? "R7 bad index zeros" : "R5 R6 R8 sample value");
        end

        // R6 explicit saturation: zero taps, shift 15
        write_coef(0, 16'h0000);
        write_coef(1, 16'h0000);
        run_frame(64'h0F_78_78_78_78_78_78_78, 1'b0, "R6 clamp to limits");
        chk(h1m == -32768, "R6 low limit reached", h1m, -32768);

        // R9 history preset
        write_coef(0, 16'h0800);
        write_coef(1, 16'h0800);
        hist_h1_in = 16'sd1000;
        hist_h2_in = 16'sd500;
        hist_load  = 1'b1;
        @(posedge clk);
        #1;
        hist_load = 1'b0;
        @(negedge clk);
        h1m = 1000;
        h2m = 500;
        send_byte(8'h00);
        send_byte(8'h00);
        recv(1500, 1'b0, "R9 preset history used");
        h2m = 1000; h1m = 1500;
        recv(model(0, 0, 2048, 2048, 1500, 1000), 1'b0, "R9 R8 after preset");

        // R1 reset mid-frame clears history and coefficients
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset mid-frame",
            int'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) cm[i] = 0;
        h1m = 0; h2m = 0;
        @(negedge clk);
        write_coef(0, 16'h0800);
        run_frame(64'h00_00_00_00_00_00_00_00, 1'b0, "R1 history zero after reset");

        // R11 rewrite between identical frames
        write_coef(2, 16'h0400);
        run_frame(64'h12_33_33_33_33_33_33_33, 1'b0, "R11 first coefficient set");
        write_coef(2, 16'h0C00);
        write_coef(3, 16'hFE00);
        run_frame(64'h12_33_33_33_33_33_33_33, 1'b0, "R11 rewritten coefficients");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule